// File: doc/BRIEF.md
# Programmable Parallel Peripheral Interface

This block is a parallel I/O controller that sits on a simple 8-bit host bus. It exposes three 8-bit ports (A, B and C) and one control register, all reached through a two-bit register address while an active-low select is held low. Host reads and writes use separate active-low read and write strobes. Port pins are modelled as three vectors per port: the live input value, the output latch value and an output enable that an external tristate driver can use.

A host write to the control register is decoded by its top bit. With the top bit set, the byte is a configuration word that sets the direction of each port group and clears every output latch. With the top bit clear, the byte is a command that loads one chosen bit of the port C latch. Port C is split into nibbles: the high nibble travels with port A in one group, and the low nibble travels with port B in the other. Only the basic, non-handshaking operating mode is provided.

Write strobes are sampled on the system clock. A write commits on the first clock edge where select and write are both low, and a write strobe held low over several edges commits once. Reads are combinational while select and read are both low.

Top module: `par_io_unit`

## Requirements
- R1: After reset every output-enable bit is 0, every output latch is 0, and a read of the control register (address 3) returns 0x9B.
- R2: Registers change only on a write with busCsN low; busRdOe is 1 only while busCsN and busRdN are both low, and 0 otherwise.
- R3: busAddr selects the register: 0 is port A, 1 is port B, 2 is port C, 3 is the control register.
- R4: A control write with bit 7 = 1 and bits 6, 5 and 2 all 0 is a configuration word. Bit 4 sets the direction of port A, bit 3 the direction of port C bits 7:4, bit 1 the direction of port B and bit 0 the direction of port C bits 3:0, where 1 is input. Each output-enable bit is 1 exactly when its port or nibble is an output. The word also clears all three output latches.
- R5: A control write with bit 7 = 1 and any of bits 6, 5 or 2 set is ignored: directions, latches and the control read value are unchanged.
- R6: A control write with bit 7 = 0 loads bit 0 of the written byte into the port C latch bit indexed by bits 3:1. No other latch bit changes.
- R7: A read of a port (or port C nibble) set as output returns its latch. A read of one set as input returns the live input pins. Port C is resolved per nibble. A control register read returns the last accepted configuration word.
- R8: A data write to port A, B or C loads that port's latch whatever its direction, and paOut, pbOut and pcOut always show the latches.
- R9: A write strobe held low over several clock edges commits only the data present on the first edge.
- R10: Configuration word 0x80 makes all 24 lines outputs. Word 0x88 makes port C bits 7:4 input and all other lines outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busCsN | input | 1 | Active-low chip select |
| busRdN | input | 1 | Active-low read strobe |
| busWrN | input | 1 | Active-low write strobe |
| busAddr | input | 2 | Register address |
| busWrData | input | 8 | Host write data |
| busRdData | output | 8 | Host read data |
| busRdOe | output | 1 | Read data output enable |
| paIn | input | 8 | Port A pin inputs |
| paOut | output | 8 | Port A output latch |
| paOe | output | 8 | Port A output enables |
| pbIn | input | 8 | Port B pin inputs |
| pbOut | output | 8 | Port B output latch |
| pbOe | output | 8 | Port B output enables |
| pcIn | input | 8 | Port C pin inputs |
| pcOut | output | 8 | Port C output latch |
| pcOe | output | 8 | Port C output enables, per nibble |

## Verification
The hardest case to reach from the ports is a port C read with split nibble directions, where one half comes from live pins and the other from a latch. That latch must have been written after the configuration word, because the word clears it. The stimulus sets the nibbles to opposite directions, writes port C, sets the pins to a pattern that differs from the latch, and checks both halves. A long write strobe with data that changes while the strobe is held is used to check that the write commits once. A random phase then mixes configuration words, rejected mode words, bit commands and port writes, with a behavioural model compared on every clock.

// File: rtl/par_io_pkg.sv
package par_io_pkg;
  localparam int PORT_W = 8;
  localparam int NIB_W  = PORT_W / 2;
  localparam int IDX_W  = $clog2(PORT_W);

  // configuration word field positions
  localparam int CFG_FMT   = 7;
  localparam int CFG_DIR_A = 4;
  localparam int CFG_DIR_CH = 3;
  localparam int CFG_DIR_B = 1;
  localparam int CFG_DIR_CL = 0;

  localparam logic [PORT_W-1:0] CFG_RESET = 8'h9B;

  typedef enum logic [1:0] {
    SEL_PA  = 2'd0,
    SEL_PB  = 2'd1,
    SEL_PC  = 2'd2,
    SEL_CFG = 2'd3
  } regSel_e;

  typedef struct packed {
    logic wrPortA;
    logic wrPortB;
    logic wrPortC;
    logic wrCfg;
    logic wrBitOp;
  } busStrobes_t;
endpackage

// File: rtl/par_io_ctrl.sv
module par_io_ctrl
  import par_io_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        rdN,
  input  logic        wrN,
  input  logic [1:0]  addr,
  input  logic [3:0]  fmtBits,   // {bit7, bit6, bit5, bit2} of write data
  output busStrobes_t strobes,
  output logic        rdOe
);
  logic wrActive;
  logic wrPrev;
  logic wrPulse;
  logic modeBitsZero;
  regSel_e sel;

  assign wrActive     = !csN && !wrN;
  assign wrPulse      = wrActive && !wrPrev;
  assign modeBitsZero = (fmtBits[2:0] == 3'b000);
  assign sel          = regSel_e'(addr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wrPrev <= 1'b0;
    else       wrPrev <= wrActive;
  end

  always_comb begin
    strobes = '0;
    if (wrPulse) begin
      unique case (sel)
        SEL_PA:  strobes.wrPortA = 1'b1;
        SEL_PB:  strobes.wrPortB = 1'b1;
        SEL_PC:  strobes.wrPortC = 1'b1;
        SEL_CFG: begin
          if (fmtBits[3]) strobes.wrCfg   = modeBitsZero;
          else            strobes.wrBitOp = 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign rdOe = !csN && !rdN;

  // R9: a write strobe produces at most one commit pulse per assertion
  assert_single_commit_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes != '0) |=> (strobes == '0));

  // R2: no strobe while deselected
  assert_no_strobe_deselected_R2: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> (strobes == '0));
endmodule

// File: rtl/par_io_dp.sv
module par_io_dp
  import par_io_pkg::*;
#(
  parameter int W = PORT_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  busStrobes_t  strobes,
  input  logic [W-1:0] wrData,
  input  logic [1:0]   addr,
  input  logic [W-1:0] paIn,
  input  logic [W-1:0] pbIn,
  input  logic [W-1:0] pcIn,
  output logic [W-1:0] paOut,
  output logic [W-1:0] paOe,
  output logic [W-1:0] pbOut,
  output logic [W-1:0] pbOe,
  output logic [W-1:0] pcOut,
  output logic [W-1:0] pcOe,
  output logic [W-1:0] rdData
);
  localparam int HALF = W / 2;
  localparam int IW   = $clog2(W);

  logic [W-1:0] latA, latB, latC, cfgWord;
  logic dirAIn, dirBIn, dirCHiIn, dirCLoIn;
  logic [IW-1:0] bitIdx;
  logic [W-1:0] pcView;

  assign dirAIn   = cfgWord[CFG_DIR_A];
  assign dirBIn   = cfgWord[CFG_DIR_B];
  assign dirCHiIn = cfgWord[CFG_DIR_CH];
  assign dirCLoIn = cfgWord[CFG_DIR_CL];
  assign bitIdx   = wrData[IW:1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latA    <= '0;
      latB    <= '0;
      latC    <= '0;
      cfgWord <= CFG_RESET;
    end else if (strobes.wrCfg) begin
      cfgWord <= wrData;
      latA    <= '0;
      latB    <= '0;
      latC    <= '0;
    end else begin
      if (strobes.wrPortA) latA <= wrData;
      if (strobes.wrPortB) latB <= wrData;
      if (strobes.wrPortC) latC <= wrData;
      if (strobes.wrBitOp) latC[bitIdx] <= wrData[0];
    end
  end

  assign paOut = latA;
  assign pbOut = latB;
  assign pcOut = latC;
  assign paOe  = {W{!dirAIn}};
  assign pbOe  = {W{!dirBIn}};

  generate
    for (genvar n = 0; n < 2; n++) begin : g_cnib
      logic nibIn;
      if (n == 1) begin : g_hi
        assign nibIn = dirCHiIn;
      end else begin : g_lo
        assign nibIn = dirCLoIn;
      end
      assign pcOe[n*HALF +: HALF]   = {HALF{!nibIn}};
      assign pcView[n*HALF +: HALF] = nibIn ? pcIn[n*HALF +: HALF]
                                            : latC[n*HALF +: HALF];
    end
  endgenerate

  always_comb begin
    unique case (regSel_e'(addr))
      SEL_PA:  rdData = dirAIn ? paIn : latA;
      SEL_PB:  rdData = dirBIn ? pbIn : latB;
      SEL_PC:  rdData = pcView;
      default: rdData = cfgWord;
    endcase
  end

  // R4: a configuration word leaves every latch cleared
  assert_cfg_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrCfg |=> (latA == '0 && latB == '0 && latC == '0));

  // R6: a bit command changes at most one port C latch bit
  assert_bitop_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrBitOp |=> ($countones(latC ^ $past(latC)) <= 1));

  // R2: without a strobe nothing in the register file moves
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes == '0) |=> ($stable(latA) && $stable(latB) && $stable(latC) && $stable(cfgWord)));
endmodule

// File: rtl/par_io_unit.sv
module par_io_unit
  import par_io_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busCsN,
  input  logic              busRdN,
  input  logic              busWrN,
  input  logic [1:0]        busAddr,
  input  logic [PORT_W-1:0] busWrData,
  output logic [PORT_W-1:0] busRdData,
  output logic              busRdOe,
  input  logic [PORT_W-1:0] paIn,
  output logic [PORT_W-1:0] paOut,
  output logic [PORT_W-1:0] paOe,
  input  logic [PORT_W-1:0] pbIn,
  output logic [PORT_W-1:0] pbOut,
  output logic [PORT_W-1:0] pbOe,
  input  logic [PORT_W-1:0] pcIn,
  output logic [PORT_W-1:0] pcOut,
  output logic [PORT_W-1:0] pcOe
);
  busStrobes_t strobes;
  logic [3:0]  fmtBits;

  assign fmtBits = {busWrData[CFG_FMT], busWrData[6], busWrData[5], busWrData[2]};

  par_io_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .csN     (busCsN),
    .rdN     (busRdN),
    .wrN     (busWrN),
    .addr    (busAddr),
    .fmtBits (fmtBits),
    .strobes (strobes),
    .rdOe    (busRdOe)
  );

  par_io_dp #(.W(PORT_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (busWrData),
    .addr    (busAddr),
    .paIn    (paIn),
    .pbIn    (pbIn),
    .pcIn    (pcIn),
    .paOut   (paOut),
    .paOe    (paOe),
    .pbOut   (pbOut),
    .pbOe    (pbOe),
    .pcOut   (pcOut),
    .pcOe    (pcOe),
    .rdData  (busRdData)
  );

  // R2: deselected block never enables its read drivers
  assert_rdoe_deselected_R2: assert property (@(posedge clk) disable iff (!rstN)
    busCsN |-> !busRdOe);

  // R4: port enables are all-or-nothing per port
  assert_port_oe_whole_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(paOe) == 0 || $countones(paOe) == PORT_W) &&
    ($countones(pbOe) == 0 || $countones(pbOe) == PORT_W));
endmodule

// File: tb/par_io_unit_tb_top.sv
`timescale 1ns/1ps
module par_io_unit_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busCsN = 1'b1, busRdN = 1'b1, busWrN = 1'b1;
  logic [1:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic busRdOe;
  logic [7:0] paIn = '0, pbIn = '0, pcIn = '0;
  logic [7:0] paOut, paOe, pbOut, pbOe, pcOut, pcOe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  par_io_unit dut_i (.*);

  // behavioural model
  logic [7:0] mA = 0, mB = 0, mC = 0, mCfg = 8'h9B;
  bit mPrev = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mA = 0; mB = 0; mC = 0; mCfg = 8'h9B; mPrev = 0;
    end else begin
      bit act;
      act = !busCsN && !busWrN;
      if (act && !mPrev) begin
        case (busAddr)
          2'd0: mA = busWrData;
          2'd1: mB = busWrData;
          2'd2: mC = busWrData;
          default: begin
            if (busWrData[7]) begin
              if (busWrData[6:5] == 2'b00 && busWrData[2] == 1'b0) begin
                mCfg = busWrData; mA = 0; mB = 0; mC = 0;
              end
            end else begin
              mC[busWrData[3:1]] = busWrData[0];
            end
          end
        endcase
      end
      mPrev = act;
    end
  end

  function automatic logic [7:0] expRead(input logic [1:0] a);
    logic [7:0] r;
    case (a)
      2'd0: r = mCfg[4] ? paIn : mA;
      2'd1: r = mCfg[1] ? pbIn : mB;
      2'd2: begin
        r[7:4] = mCfg[3] ? pcIn[7:4] : mC[7:4];
        r[3:0] = mCfg[0] ? pcIn[3:0] : mC[3:0];
      end
      default: r = mCfg;
    endcase
    return r;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // model comparison on every clock
  always @(posedge clk) begin
    #1;
    if (rstN && !done) begin
      chk("R8 paOut", paOut, mA);
      chk("R8 pbOut", pbOut, mB);
      chk("R6 pcOut", pcOut, mC);
      chk("R4 paOe", paOe, mCfg[4] ? 8'h00 : 8'hFF);
      chk("R4 pbOe", pbOe, mCfg[1] ? 8'h00 : 8'hFF);
      chk("R4 pcOe", pcOe, {mCfg[3] ? 4'h0 : 4'hF, mCfg[0] ? 4'h0 : 4'hF});
      chk("R2 busRdOe", {7'd0, busRdOe}, {7'd0, (!busCsN && !busRdN)});
      if (busRdOe) chk("R7 busRdData", busRdData, expRead(busAddr));
    end
  end

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busCsN = 0; busWrN = 0; busAddr = a; busWrData = d;
    @(negedge clk);
    busCsN = 1; busWrN = 1;
    @(negedge clk);
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    busCsN = 0; busRdN = 0; busAddr = a;
    #1;
    d = busRdData; oe = busRdOe;
    @(negedge clk);
    busCsN = 1; busRdN = 1;
  endtask

  initial begin
    logic [7:0] rd;
    logic oe;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 paOe", paOe, 8'h00);
    chk("R1 pbOe", pbOe, 8'h00);
    chk("R1 pcOe", pcOe, 8'h00);
    chk("R1 latches", paOut | pbOut | pcOut, 8'h00);
    busRead(2'd3, rd, oe);
    chk("R1 cfg read", rd, 8'h9B);

    // R10 all outputs
    busWrite(2'd3, 8'h80);
    chk("R10 paOe", paOe, 8'hFF);
    chk("R10 pcOe", pcOe, 8'hFF);
    busWrite(2'd0, 8'h5A);
    busWrite(2'd1, 8'hC3);
    busWrite(2'd2, 8'h96);
    paIn = 8'h11; pbIn = 8'h22; pcIn = 8'h33;
    busRead(2'd0, rd, oe); chk("R3 R7 read A", rd, 8'h5A);
    busRead(2'd1, rd, oe); chk("R3 R7 read B", rd, 8'hC3);
    busRead(2'd2, rd, oe); chk("R3 R7 read C", rd, 8'h96);

    // R6 bit commands: index 5 <- 1, index 4 <- 0
    busWrite(2'd3, 8'h0B);
    chk("R6 set bit5", pcOut, 8'hB6);
    busWrite(2'd3, 8'h08);
    chk("R6 clear bit4", pcOut, 8'hA6);

    // R10/R4 upper C input, latches cleared
    busWrite(2'd3, 8'h88);
    chk("R4 clear A", paOut, 8'h00);
    chk("R4 clear C", pcOut, 8'h00);
    chk("R10 pcOe split", pcOe, 8'h0F);
    chk("R10 paOe", paOe, 8'hFF);
    busWrite(2'd2, 8'hFF);
    pcIn = 8'h3C;
    busRead(2'd2, rd, oe); chk("R7 split C read", rd, 8'h3F);

    // R5 word with a mode bit set is ignored
    busWrite(2'd3, 8'h84);
    busRead(2'd3, rd, oe); chk("R5 cfg unchanged", rd, 8'h88);
    chk("R5 latch unchanged", pcOut, 8'hFF);
    busWrite(2'd3, 8'hA0);
    chk("R5 oe unchanged", pcOe, 8'h0F);

    // R2 deselected access
    @(negedge clk);
    busCsN = 1; busWrN = 0; busAddr = 2'd0; busWrData = 8'hEE;
    @(negedge clk); @(negedge clk);
    busWrN = 1;
    chk("R2 write ignored", paOut, 8'h00);
    busRdN = 0; #1;
    chk("R2 rdOe deselected", {7'd0, busRdOe}, 8'h00);
    @(negedge clk); busRdN = 1;

    // R8 writes to input ports load the latch
    busWrite(2'd3, 8'h9B);
    busWrite(2'd0, 8'h77);
    chk("R8 latch on input port", paOut, 8'h77);
    chk("R8 oe off", paOe, 8'h00);
    paIn = 8'h12;
    busRead(2'd0, rd, oe); chk("R7 input read A", rd, 8'h12);
    chk("R2 rdOe during read", {7'd0, oe}, 8'h01);

    // R4 mixed directions
    busWrite(2'd3, 8'h92);
    chk("R4 A in", paOe, 8'h00);
    chk("R4 B in", pbOe, 8'h00);
    chk("R4 C out", pcOe, 8'hFF);

    // R9 long strobe with changing data
    busWrite(2'd3, 8'h80);
    @(negedge clk);
    busCsN = 0; busWrN = 0; busAddr = 2'd1; busWrData = 8'h11;
    @(negedge clk); busWrData = 8'h22;
    @(negedge clk); busWrData = 8'h33;
    @(negedge clk); busCsN = 1; busWrN = 1;
    @(negedge clk);
    chk("R9 first data only", pbOut, 8'h11);

    // random mix, checked by the model
    for (int i = 0; i < 400; i++) begin
      logic [1:0] a;
      logic [7:0] d;
      a = 2'($urandom_range(0, 3));
      d = 8'($urandom);
      paIn = 8'($urandom); pbIn = 8'($urandom); pcIn = 8'($urandom);
      if ($urandom_range(0, 1) == 1) busWrite(a, d);
      else busRead(a, rd, oe);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule